// File: doc/BRIEF.md
# Compensated Reference-Tick Counter

A 64-bit free-running time base that moves forward only on ticks of a slow reference clock. The tick arrives as a single-cycle enable that has already been synchronised into the fast clock domain. On each tick the count grows by a programmable whole-number step: the fast-to-reference rate ratio, rounded. The rounding error is expressed in hundredths of a count and kept in a signed correction word. A fractional accumulator sums that error and adds or drops one count whenever a whole unit has built up. Over a long run the average rate therefore matches the true ratio.

Software programs the step and the correction word, then sets the run bit. It reads the count through a small word-addressed register port. A low-word read captures the upper half in a shadow register, so the high-word read that follows belongs to the same instant. A 32-bit reader can simply use the low word and let it wrap at 2^32.

Top module: `rtc_comp_counter`

## Requirements
- R1: After reset the count, the accumulator, the step, the correction word and the run bit are all zero, and reads of the count return 0.
- R2: The count changes only on a cycle with `tick_i` high while the run bit (bit 0 of address 2) is 1. Ticks with the run bit at 0 leave the count unchanged.
- R3: With a zero correction magnitude, each counted tick adds the step register (address 0, 32 bits) to the count.
- R4: The correction word sits at address 1. Bit 31 is the sign (1 = add an extra count, 0 = remove a count) and bits 30:0 hold the magnitude m in hundredths. Starting from reset, after N counted ticks the count equals N*step + floor(N*m/100) when the sign is 1, and N*step - floor(N*m/100) when the sign is 0.
- R5: A magnitude above 99 is treated as 99.
- R6: While the step is zero the count and the accumulator both hold, even with the run bit set and ticks arriving.
- R7: A read strobe to address 3 returns count[31:0] on `rdata_o` one cycle later and captures count[63:32] into a shadow. A read of address 4 returns the shadow. The low word wraps at 2^32.
- R8: A tick in the same cycle as a read or a register write uses the pre-tick count and the old register value. A written step first applies on the following tick.
- R9: Step and correction read back exactly as written. The run register reads back only bit 0. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Synchronised one-cycle reference tick |
| we_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
Two things can happen in the same cycle: a reference tick that carries out of the low 32 bits, and a low-word read. The bench sets a step of 2^31, so the second tick wraps the low word into the high word, and it issues the low-word read on exactly that tick. The low read must return the pre-tick value 0x80000000, and the following high read must return the pre-tick shadow 0. Fresh reads afterwards must show the post-carry values 0 and 1. A step write that lands on a tick is judged the same way: the tick must use the old step.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int ADDR_STEP = 0;
  localparam int ADDR_CORR = 1;
  localparam int ADDR_RUN  = 2;
  localparam int ADDR_CLO  = 3;
  localparam int ADDR_CHI  = 4;
  localparam int SIGN_BIT  = 31;
endpackage

// File: rtl/rcc_frac_acc.sv
module rcc_frac_acc #(
  parameter int FRAC_ONE = 100,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] corr_i,
  output logic              adj_up_o,
  output logic              adj_dn_o
);
  localparam int FRAC_W  = $clog2(FRAC_ONE);
  localparam int SUM_W   = FRAC_W + 1;
  localparam int MAG_MAX = FRAC_ONE - 1;

  logic [FRAC_W-1:0] acc_q, acc_d, mag;
  logic [SUM_W-1:0]  sum;
  logic              carry, sgn;

  assign sgn = corr_i[rcc_pkg::SIGN_BIT];

  always_comb begin
    if (corr_i[DATA_W-2:0] > (DATA_W-1)'(MAG_MAX)) mag = FRAC_W'(MAG_MAX);
    else                                          mag = corr_i[FRAC_W-1:0];
    sum   = SUM_W'(acc_q) + SUM_W'(mag);
    carry = sum >= SUM_W'(FRAC_ONE);
    acc_d = carry ? FRAC_W'(sum - SUM_W'(FRAC_ONE)) : FRAC_W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (adv_i) acc_q <= acc_d;
  end

  assign adj_up_o = adv_i & carry & sgn;
  assign adj_dn_o = adv_i & carry & ~sgn;

  // R4: accumulator never holds a whole unit
  p_acc_below_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < FRAC_W'(FRAC_ONE));
  // R6: no advance, accumulator holds
  p_acc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(acc_q));
endmodule

// File: rtl/rcc_count_core.sv
module rcc_count_core #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [DATA_W-1:0] step_i,
  input  logic              adj_up_i,
  input  logic              adj_dn_i,
  output logic              adv_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign adv_o = tick_i & run_i & (step_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_o) cnt_q <= cnt_q + CNT_W'(step_i) + CNT_W'(adj_up_i) - CNT_W'(adj_dn_i);
  end

  assign cnt_o = cnt_q;

  // R2: no run, no movement
  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i || !tick_i) |=> $stable(cnt_q));
  // R6: zero step freezes the count
  p_zero_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == '0) |=> $stable(cnt_q));
  // R3: a counted tick moves by step within one unit
  p_step_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> ((cnt_q - $past(cnt_q) - CNT_W'($past(step_i)) + CNT_W'(1)) <= CNT_W'(2)));
  // R4: up and down corrections exclusive
  p_adj_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adj_up_i && adj_dn_i));
endmodule

// File: rtl/rcc_regs.sv
module rcc_regs #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] step_o,
  output logic [DATA_W-1:0] corr_o,
  output logic              run_o,
  output logic [DATA_W-1:0] rdata_o
);
  import rcc_pkg::*;
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] step_q, corr_q, rdata_q, rd_mux;
  logic [HI_W-1:0]   shadow_q;
  logic              run_q, rd_lo;

  assign rd_lo = rd_i && (addr_i == ADDR_W'(ADDR_CLO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      corr_q <= '0;
      run_q  <= 1'b0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(ADDR_STEP)) step_q <= wdata_i;
      if (addr_i == ADDR_W'(ADDR_CORR)) corr_q <= wdata_i;
      if (addr_i == ADDR_W'(ADDR_RUN))  run_q  <= wdata_i[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (addr_i == ADDR_W'(ADDR_STEP)) rd_mux = step_q;
    else if (addr_i == ADDR_W'(ADDR_CORR)) rd_mux = corr_q;
    else if (addr_i == ADDR_W'(ADDR_RUN))  rd_mux = DATA_W'(run_q);
    else if (addr_i == ADDR_W'(ADDR_CLO))  rd_mux = cnt_i[DATA_W-1:0];
    else if (addr_i == ADDR_W'(ADDR_CHI))  rd_mux = DATA_W'(shadow_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else begin
      if (rd_i)  rdata_q  <= rd_mux;
      if (rd_lo) shadow_q <= cnt_i[CNT_W-1:DATA_W];
    end
  end

  assign step_o  = step_q;
  assign corr_o  = corr_q;
  assign run_o   = run_q;
  assign rdata_o = rdata_q;

  // R7: low read captures the high half
  p_shadow_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> (shadow_q == $past(cnt_i[CNT_W-1:DATA_W])));
  // R7: low read returns pre-edge low half
  p_low_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> (rdata_q == $past(cnt_i[DATA_W-1:0])));
  // R7: shadow moves only on low read
  p_shadow_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo |=> $stable(shadow_q));
endmodule

// File: rtl/rtc_comp_counter.sv
module rtc_comp_counter #(
  parameter int CNT_W    = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int FRAC_ONE = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] step, corr;
  logic              run, adv, adj_up, adj_dn;

  rcc_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk_i, .rst_ni, .we_i, .rd_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .step_o(step), .corr_o(corr), .run_o(run), .rdata_o
  );

  rcc_count_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) core_i (
    .clk_i, .rst_ni, .tick_i, .run_i(run), .step_i(step),
    .adj_up_i(adj_up), .adj_dn_i(adj_dn), .adv_o(adv), .cnt_o(cnt)
  );

  rcc_frac_acc #(.FRAC_ONE(FRAC_ONE), .DATA_W(DATA_W)) frac_i (
    .clk_i, .rst_ni, .adv_i(adv), .corr_i(corr),
    .adj_up_o(adj_up), .adj_dn_o(adj_dn)
  );
endmodule

// File: tb/rtc_comp_counter_tb_top.sv
module rtc_comp_counter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        we_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  rtc_comp_counter dut_i (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic op(input bit t, input bit w, input bit r, input int a, input logic [31:0] d);
    tick_i = t; we_i = w; rd_i = r; addr_i = 3'(a); wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 0; we_i = 0; rd_i = 0; wdata_i = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    op(0, 0, 1, a, '0);
    v = rdata_o;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    op(0, 1, 0, a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) op(1, 0, 0, 0, '0);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(3, lo);
    rd(4, hi);
    v = {hi, lo};
  endtask

  initial begin
    logic [31:0] v;
    logic [63:0] c;
    int steps[3] = '{1, 5, 1000};
    int mags[6]  = '{0, 1, 33, 50, 99, 150};
    int n = 150;

    @(negedge clk_i);
    do_reset();
    // R1 reset state
    rd64(c); chk("R1 count", c, 64'd0);
    rd(0, v); chk("R1 step", 64'(v), 64'd0);
    rd(1, v); chk("R1 corr", 64'(v), 64'd0);
    rd(2, v); chk("R1 run", 64'(v), 64'd0);

    // R2 ticks without run
    wr(0, 32'd7);
    ticks(20);
    rd64(c); chk("R2 idle ticks", c, 64'd0);

    // R9 readback
    wr(0, 32'h1234_5678); rd(0, v); chk("R9 step", 64'(v), 64'h1234_5678);
    wr(1, 32'h8000_002A); rd(1, v); chk("R9 corr", 64'(v), 64'h8000_002A);
    wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R9 run", 64'(v), 64'd1);
    rd(7, v); chk("R9 unmapped", 64'(v), 64'd0);

    // R3 R4 R5 sweep
    foreach (steps[si]) foreach (mags[mi]) for (int sg = 0; sg < 2; sg++) begin
      longint m, e;
      m = (mags[mi] > 99) ? 99 : mags[mi];
      e = longint'(n) * steps[si];
      if (sg == 1) e = e + (longint'(n) * m) / 100;
      else         e = e - (longint'(n) * m) / 100;
      do_reset();
      wr(0, 32'(steps[si]));
      wr(1, {sg[0], 31'(mags[mi])});
      wr(2, 32'd1);
      ticks(n);
      rd64(c);
      if (mags[mi] == 0)      chk("R3 sweep", c, 64'(e));
      else if (mags[mi] > 99) chk("R5 sweep", c, 64'(e));
      else                    chk("R4 sweep", c, 64'(e));
    end

    // R2 run cleared stops counting
    do_reset();
    wr(0, 32'd4); wr(2, 32'd1); ticks(10);
    wr(2, 32'd0); ticks(10);
    rd64(c); chk("R2 stop", c, 64'd40);

    // R6 zero step freezes count and accumulator
    do_reset();
    wr(1, 32'h8000_0063); wr(2, 32'd1);
    ticks(300);
    rd64(c); chk("R6 frozen", c, 64'd0);
    wr(0, 32'd1); ticks(1);
    rd64(c); chk("R6 acc held", c, 64'd1);

    // R7 R8 read coincident with carry into high word
    do_reset();
    wr(0, 32'h8000_0000); wr(2, 32'd1);
    ticks(1);
    op(1, 0, 1, 3, '0); v = rdata_o;
    chk("R8 lo with tick", 64'(v), 64'h8000_0000);
    rd(4, v); chk("R7 coherent hi", 64'(v), 64'd0);
    rd(3, v); chk("R7 lo wrap", 64'(v), 64'd0);
    rd(4, v); chk("R7 hi carry", 64'(v), 64'd1);

    // R8 step write on a tick
    do_reset();
    wr(0, 32'd3); wr(2, 32'd1);
    op(1, 1, 0, 0, 32'd10);
    rd64(c); chk("R8 old step", c, 64'd3);
    ticks(1);
    rd64(c); chk("R8 new step", c, 64'd13);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule